// File: doc/BRIEF.md
# Audio DAC Sample Intake Controller

This block sits in front of a stereo bitstream audio converter. It takes 16-bit samples through two sample-data write ports, one per channel. It divides the converter clock into one sample tick per sample period. On each tick it hands a left and right sample to the modulator. It also tells software and two DMA channels when the next period's samples are still missing.

The sample period is the upsampling ratio times eight converter-clock cycles. The standard ratio is 128. An alternate-ratio bit picks 125 for the 48 kHz family of rates and 136 for the 44.1 kHz family. A new period length is adopted only at a tick, so no period is ever cut short or stretched.

Mono mode sends channel 0 to both outputs. Compact mode packs both channels into a single 32-bit write on the channel-0 port. In both of these single-port modes the channel-1 DMA request stays low. If a tick arrives before the samples are complete, the old output is held and a sticky underrun flag is raised.

Top module: `audio_intake_ctrl`

## Requirements
- R1: With `altRatio` low, `sampleTick` pulses for one cycle every 1024 converter-clock cycles.
- R2: With `altRatio` high and `rateCode` in the 48 kHz family, the tick spacing is 1000 cycles. That family is codes 0 (8k), 2 (12k), 3 (16k), 5 (24k), 6 (32k) and 8 (48k).
- R3: With `altRatio` high and `rateCode` 1, 4 or 7 (11.025k, 22.05k, 44.1k), the tick spacing is 1088 cycles. Unused codes 9 to 15 behave as the 48 kHz family.
- R4: A change of `altRatio` or `rateCode` takes effect only after the next tick. The period in progress keeps its length.
- R5: In stereo mode (`monoMode` and `compactMode` low), the cycle after a tick with complete samples gives `leftOut` = channel-0 `wrData[15:0]` and `rightOut` = channel-1 `wrData[15:0]`.
- R6: In mono mode, both outputs take channel-0 `wrData[15:0]`, and channel-1 writes are ignored.
- R7: In compact mode, `leftOut` takes channel-0 bits [15:0] and `rightOut` takes bits [31:16]. When mono is also set, both outputs take bits [15:0].
- R8: `txReady` is high while the block is running and the samples for the next period are not yet complete.
- R9: `dmaReq0` is high while running and no channel-0 sample is staged. `dmaReq1` is high while running in stereo mode and no channel-1 sample is staged, and it is never high in mono or compact mode.
- R10: A tick with incomplete samples leaves both outputs unchanged and sets `underrun`. `underrun` stays set until reset.
- R11: While `enable` is low, the counter is held at zero and staged samples are dropped. `txReady`, `dmaReq0`, `dmaReq1` and `sampleTick` are low. After `enable` rises, the first tick comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable |
| altRatio | input | 1 | Selects the alternate upsampling ratio |
| rateCode | input | 4 | Sample-rate code |
| monoMode | input | 1 | Channel 0 drives both outputs |
| compactMode | input | 1 | Both channels packed into the channel-0 write |
| wrCh0 | input | 1 | Write strobe, channel-0 sample register |
| wrCh1 | input | 1 | Write strobe, channel-1 sample register |
| wrData | input | 32 | Write data |
| sampleTick | output | 1 | One-cycle pulse at each period boundary |
| txReady | output | 1 | Next-period samples still needed |
| dmaReq0 | output | 1 | DMA request for the channel-0 register |
| dmaReq1 | output | 1 | DMA request for the channel-1 register |
| underrun | output | 1 | Sticky missed-sample flag |
| leftOut | output | 16 | Left sample to the modulator |
| rightOut | output | 16 | Right sample to the modulator |

## Verification
The tick spacing is measured in all three ratio settings, including one unused rate code. Changing the configuration in mid-period shows whether the new length is adopted at the wrap or at once. The routing is driven with distinct upper and lower halves in stereo, mono, compact, and mono-plus-compact. A wrong half or a wrong channel therefore shows as a different output value, and an ignored channel-1 write in mono would otherwise be visible. A run with only channel 0 written separates holding the outputs from committing stale data. A disable and re-enable sequence checks the cleared flags and the restart latency.

// File: rtl/aic_pkg.sv
package aic_pkg;

  localparam int RATE_W = 4;

  typedef enum logic [1:0] {
    RSEL_CH1  = 2'd0,
    RSEL_LOW  = 2'd1,
    RSEL_HIGH = 2'd2
  } rightSel_e;

  typedef struct packed {
    logic      load0;
    logic      load1;
    logic      commit;
    rightSel_e rightSel;
  } dpStrobe_t;

  function automatic logic isFamily44(input logic [RATE_W-1:0] code);
    return (code == RATE_W'(1)) || (code == RATE_W'(4)) || (code == RATE_W'(7));
  endfunction

endpackage

// File: rtl/aic_ctrl.sv
module aic_ctrl
  import aic_pkg::*;
#(
  parameter int RATIO_STD   = 128,
  parameter int RATIO_ALT48 = 125,
  parameter int RATIO_ALT44 = 136,
  parameter int OSR_MULT    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              altRatio,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              monoMode,
  input  logic              compactMode,
  input  logic              wrCh0,
  input  logic              wrCh1,
  output dpStrobe_t         strobe,
  output logic              sampleTick,
  output logic              txReady,
  output logic              dmaReq0,
  output logic              dmaReq1,
  output logic              underrun
);

  localparam int MAX_RATIO_A = (RATIO_STD > RATIO_ALT48) ? RATIO_STD : RATIO_ALT48;
  localparam int MAX_RATIO   = (MAX_RATIO_A > RATIO_ALT44) ? MAX_RATIO_A : RATIO_ALT44;
  localparam int CNT_W       = $clog2(MAX_RATIO * OSR_MULT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] cfgPeriod;
  logic             running;
  logic             have0;
  logic             have1;
  logic             underrunQ;
  logic             singleMode;
  logic             complete;
  logic             tick;

  always_comb begin
    int ratio;
    if (!altRatio)               ratio = RATIO_STD;
    else if (isFamily44(rateCode)) ratio = RATIO_ALT44;
    else                         ratio = RATIO_ALT48;
    cfgPeriod = CNT_W'(ratio * OSR_MULT);
  end

  assign singleMode = monoMode | compactMode;
  assign complete   = have0 & (singleMode | have1);
  assign tick       = enable & (cnt == activePeriod - CNT_W'(1));

  always_comb begin
    strobe.load0  = enable & wrCh0;
    strobe.load1  = enable & wrCh1 & ~singleMode;
    strobe.commit = tick & complete;
    if (monoMode)         strobe.rightSel = RSEL_LOW;
    else if (compactMode) strobe.rightSel = RSEL_HIGH;
    else                  strobe.rightSel = RSEL_CH1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      activePeriod <= CNT_W'(RATIO_STD * OSR_MULT);
      running      <= 1'b0;
      have0        <= 1'b0;
      have1        <= 1'b0;
      underrunQ    <= 1'b0;
    end else if (!enable) begin
      cnt          <= '0;
      activePeriod <= cfgPeriod;
      running      <= 1'b0;
      have0        <= 1'b0;
      have1        <= 1'b0;
    end else begin
      running <= 1'b1;
      if (tick) begin
        cnt          <= '0;
        activePeriod <= cfgPeriod;
        if (!complete) underrunQ <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      have0 <= strobe.load0 | (have0 & ~strobe.commit);
      have1 <= strobe.load1 | (have1 & ~strobe.commit);
    end
  end

  assign sampleTick = tick;
  assign txReady    = running & ~complete;
  assign dmaReq0    = running & ~have0;
  assign dmaReq1    = running & ~singleMode & ~have1;
  assign underrun   = underrunQ;

  p_req1_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    singleMode |-> !dmaReq1);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activePeriod);

  p_period_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick) |=> $stable(activePeriod));

  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cnt == '0) && !txReady && !dmaReq0 && !dmaReq1);

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

endmodule

// File: rtl/aic_datapath.sv
module aic_datapath
  import aic_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [2*DATA_W-1:0] wrData,
  output logic [DATA_W-1:0]   leftOut,
  output logic [DATA_W-1:0]   rightOut
);

  logic [2*DATA_W-1:0] stage0;
  logic [DATA_W-1:0]   stage1;
  logic [DATA_W-1:0]   rightNext;

  always_comb begin
    unique case (strobe.rightSel)
      RSEL_LOW:  rightNext = stage0[DATA_W-1:0];
      RSEL_HIGH: rightNext = stage0[2*DATA_W-1:DATA_W];
      default:   rightNext = stage1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage0   <= '0;
      stage1   <= '0;
      leftOut  <= '0;
      rightOut <= '0;
    end else begin
      if (strobe.load0) stage0 <= wrData;
      if (strobe.load1) stage1 <= wrData[DATA_W-1:0];
      if (strobe.commit) begin
        leftOut  <= stage0[DATA_W-1:0];
        rightOut <= rightNext;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(leftOut) && $stable(rightOut));

  p_mono_same_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.rightSel == RSEL_LOW) |=> (leftOut == rightOut));

endmodule

// File: rtl/audio_intake_ctrl.sv
module audio_intake_ctrl
  import aic_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int RATIO_STD   = 128,
  parameter int RATIO_ALT48 = 125,
  parameter int RATIO_ALT44 = 136,
  parameter int OSR_MULT    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                altRatio,
  input  logic [RATE_W-1:0]   rateCode,
  input  logic                monoMode,
  input  logic                compactMode,
  input  logic                wrCh0,
  input  logic                wrCh1,
  input  logic [2*DATA_W-1:0] wrData,
  output logic                sampleTick,
  output logic                txReady,
  output logic                dmaReq0,
  output logic                dmaReq1,
  output logic                underrun,
  output logic [DATA_W-1:0]   leftOut,
  output logic [DATA_W-1:0]   rightOut
);

  dpStrobe_t strobe;

  aic_ctrl #(
    .RATIO_STD  (RATIO_STD),
    .RATIO_ALT48(RATIO_ALT48),
    .RATIO_ALT44(RATIO_ALT44),
    .OSR_MULT   (OSR_MULT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .altRatio   (altRatio),
    .rateCode   (rateCode),
    .monoMode   (monoMode),
    .compactMode(compactMode),
    .wrCh0      (wrCh0),
    .wrCh1      (wrCh1),
    .strobe     (strobe),
    .sampleTick (sampleTick),
    .txReady    (txReady),
    .dmaReq0    (dmaReq0),
    .dmaReq1    (dmaReq1),
    .underrun   (underrun)
  );

  aic_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .leftOut (leftOut),
    .rightOut(rightOut)
  );

endmodule

// File: tb/audio_intake_ctrl_test.sv
module audio_intake_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        altRatio = 1'b0;
  logic [3:0]  rateCode = 4'd0;
  logic        monoMode = 1'b0;
  logic        compactMode = 1'b0;
  logic        wrCh0 = 1'b0;
  logic        wrCh1 = 1'b0;
  logic [31:0] wrData = '0;
  logic        sampleTick, txReady, dmaReq0, dmaReq1, underrun;
  logic [15:0] leftOut, rightOut;

  int checks = 0;
  int errors = 0;
  int cycleNo = 0;
  int lastTick = 0;
  int lastGap = 0;
  bit done = 0;

  audio_intake_ctrl uut (
    .clk(clk), .rstN(rstN), .enable(enable), .altRatio(altRatio),
    .rateCode(rateCode), .monoMode(monoMode), .compactMode(compactMode),
    .wrCh0(wrCh0), .wrCh1(wrCh1), .wrData(wrData),
    .sampleTick(sampleTick), .txReady(txReady), .dmaReq0(dmaReq0),
    .dmaReq1(dmaReq1), .underrun(underrun), .leftOut(leftOut), .rightOut(rightOut)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mCnt, mPeriod;
  bit mRun, mHave0, mHave1, mUnder;
  logic [31:0] mStage0;
  logic [15:0] mStage1, mLeft, mRight;

  function automatic int cfgLen(bit alt, logic [3:0] code);
    if (!alt) return 128 * 8;
    if (code == 1 || code == 4 || code == 7) return 136 * 8;
    return 125 * 8;
  endfunction

  always @(posedge clk) begin
    bit single, complete, tick;
    if (sampleTick) begin
      lastGap  = cycleNo - lastTick;
      lastTick = cycleNo;
    end
    cycleNo++;
    if (!rstN) begin
      mCnt = 0; mPeriod = 1024; mRun = 0; mHave0 = 0; mHave1 = 0; mUnder = 0;
      mStage0 = '0; mStage1 = '0; mLeft = '0; mRight = '0;
    end else if (!enable) begin
      mCnt = 0; mPeriod = cfgLen(altRatio, rateCode); mRun = 0; mHave0 = 0; mHave1 = 0;
    end else begin
      single   = monoMode || compactMode;
      complete = mHave0 && (single || mHave1);
      tick     = (mCnt == mPeriod - 1);
      mRun = 1;
      if (tick) begin
        if (complete) begin
          mLeft  = mStage0[15:0];
          mRight = monoMode ? mStage0[15:0] : compactMode ? mStage0[31:16] : mStage1;
          mHave0 = 0; mHave1 = 0;
        end else begin
          mUnder = 1;
        end
        mCnt = 0;
        mPeriod = cfgLen(altRatio, rateCode);
      end else begin
        mCnt++;
      end
      if (wrCh0) begin mHave0 = 1; mStage0 = wrData; end
      if (wrCh1 && !single) begin mHave1 = 1; mStage1 = wrData[15:0]; end
    end
  end

  always @(negedge clk) begin
    bit single;
    if (rstN && !done) begin
      single = monoMode || compactMode;
      chk("R1 sampleTick", sampleTick, enable && (mCnt == mPeriod - 1));
      chk("R8 txReady", txReady, mRun && !(mHave0 && (single || mHave1)));
      chk("R9 dmaReq0", dmaReq0, mRun && !mHave0);
      chk("R9 dmaReq1", dmaReq1, mRun && !single && !mHave1);
      chk("R10 underrun", underrun, mUnder);
      chk("R5 leftOut", leftOut, mLeft);
      chk("R7 rightOut", rightOut, mRight);
    end
  end

  task automatic wr0(logic [31:0] d);
    @(negedge clk); wrCh0 = 1; wrData = d;
    @(negedge clk); wrCh0 = 0;
  endtask

  task automatic wr1(logic [31:0] d);
    @(negedge clk); wrCh1 = 1; wrData = d;
    @(negedge clk); wrCh1 = 0;
  endtask

  task automatic waitTick();
    @(negedge clk);
    while (!sampleTick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stereoPeriod(logic [15:0] a, logic [15:0] b, int expGap, string tag);
    wr0({16'h0, a});
    wr1({16'h0, b});
    waitTick();
    chk(tag, lastGap, expGap);
    chk("R5 stereo left", leftOut, a);
    chk("R5 stereo right", rightOut, b);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset txReady", txReady, 0);
    chk("R11 reset dmaReq0", dmaReq0, 0);
    chk("R5 reset leftOut", leftOut, 0);
    rstN = 1;
    @(negedge clk);
    // start: first tick one full period after enable
    enable = 1; lastTick = cycleNo - 1;
    stereoPeriod(16'h1111, 16'h2222, 1024, "R11 first period");
    stereoPeriod(16'h3333, 16'h4444, 1024, "R1 standard period");
    // mid-period switch to alternate ratio, 48k family
    altRatio = 1;
    stereoPeriod(16'h0101, 16'h0202, 1024, "R4 old period kept");
    stereoPeriod(16'h0303, 16'h0404, 1000, "R2 alt 48k family");
    rateCode = 4'd7;
    stereoPeriod(16'h0505, 16'h0606, 1000, "R4 old period kept");
    stereoPeriod(16'h0707, 16'h0808, 1088, "R3 alt 44.1k family");
    rateCode = 4'd9;
    stereoPeriod(16'h0909, 16'h0a0a, 1088, "R4 old period kept");
    stereoPeriod(16'h0b0b, 16'h0c0c, 1000, "R3 unused code");
    // mono
    monoMode = 1;
    wr0(32'hABCD_1234);
    wr1(32'h0000_5555);
    chk("R9 mono dmaReq1", dmaReq1, 0);
    chk("R8 mono txReady", txReady, 0);
    waitTick();
    chk("R6 mono left", leftOut, 16'h1234);
    chk("R6 mono right", rightOut, 16'h1234);
    // compact
    monoMode = 0; compactMode = 1;
    wr0(32'h7777_3333);
    waitTick();
    chk("R7 compact left", leftOut, 16'h3333);
    chk("R7 compact right", rightOut, 16'h7777);
    monoMode = 1;
    wr0(32'h9999_4444);
    waitTick();
    chk("R7 mono+compact right", rightOut, 16'h4444);
    // underrun
    monoMode = 0; compactMode = 0;
    wr0(32'h0000_AAAA);
    chk("R9 partial dmaReq0", dmaReq0, 0);
    chk("R9 partial dmaReq1", dmaReq1, 1);
    chk("R8 partial txReady", txReady, 1);
    waitTick();
    chk("R10 underrun set", underrun, 1);
    chk("R10 left held", leftOut, 16'h4444);
    chk("R10 right held", rightOut, 16'h4444);
    stereoPeriod(16'h0001, 16'h0002, 1000, "R2 period after underrun");
    chk("R10 underrun sticky", underrun, 1);
    // disable / re-enable
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R11 off txReady", txReady, 0);
    chk("R11 off dmaReq0", dmaReq0, 0);
    chk("R11 off dmaReq1", dmaReq1, 0);
    chk("R11 off sampleTick", sampleTick, 0);
    repeat (5) @(negedge clk);
    chk("R11 off held left", leftOut, 16'h0001);
    enable = 1; lastTick = cycleNo - 1;
    stereoPeriod(16'h0f0f, 16'hf0f0, 1000, "R11 restart period");
    finishRun();
  end

endmodule